// File: doc/BRIEF.md
# Comparator Control and Edge-Detect Register

This block is the digital side of an analog voltage comparator. One 32-bit control word sets the comparator's input selections, its hysteresis setting, the edge mode and the output mode. A status bit and a sticky edge flag report what the comparator output has done. The comparator's asynchronous output enters on a single pin. It passes through a two-flop synchronizer, and a one-flop history register lets the block see its changes. The edge flag drives a level interrupt request.

Software clears the flag with a handshake: it writes 1 to the clear bit and then writes 0. While the clear bit is 1, the flag is held at 0 and new edges are ignored. A second output carries the comparator result to other modules, either straight from the pin or after synchronization. The choice is made by one control bit.

The bus port is a plain single-cycle register port. A write is accepted on every clock edge where `bus_wr_en` is high. The port never stalls, so there is no back-pressure. Read data is combinational from the stored state and is always valid.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: After reset, every bit of the read data is 0, and the select outputs, the comparator output and the interrupt request are all 0.
- R2: A write stores the edge mode in bits 4:3, the output mode in bit 6, the positive select in bits 10:8, the negative select in bits 13:11, the clear bit in bit 20 and the hysteresis select in bits 26:25. The same bits read back, and `pos_sel_o`, `neg_sel_o` and `hys_sel_o` follow their fields from the edge after the write.
- R3: Read bit 21 shows the synchronized comparator level. It takes the value the raw input had two clock edges earlier.
- R4: The edge mode in bits 4:3 decides which edges are detected. 0 detects falling edges only, 1 detects rising edges only, and 2 or 3 detect both. A detected edge sets the flag one edge after bit 21 changes.
- R5: The edge flag reads in bit 23. It stays set until it is cleared, and `irq_o` equals it at all times.
- R6: A write with bit 20 = 1 clears the flag on that write's edge. While bit 20 stays 1, the flag stays 0 whatever the comparator does.
- R7: When the write that returns bit 20 to 0 lands on the same edge as a detected edge, the flag is set.
- R8: Writes to bits 21 and 23 and to every bit not named in R2 have no effect, and those unused bits read 0.
- R9: When bit 6 is 0, `cmp_out_o` follows `cmp_raw_i` with no delay. When bit 6 is 1, `cmp_out_o` equals the synchronized level in bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data: stored fields plus status bits 21 and 23 |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| pos_sel_o | output | 3 | Positive input mux select |
| neg_sel_o | output | 3 | Negative input mux select |
| hys_sel_o | output | 2 | Hysteresis select |
| cmp_out_o | output | 1 | Comparator result for other modules, raw or synchronized |
| irq_o | output | 1 | Level interrupt request, equal to the edge flag |

## Verification
Each result is due at a fixed time:

- Stored fields, select outputs and a clear request take effect on the edge of the write.
- Bit 21 changes two edges after the raw input changes.
- The edge flag follows one edge after that, three edges after the input change.
- In raw mode, `cmp_out_o` changes in the same cycle as the input.

The bench drives inputs on the falling clock edge and checks results on the next falling edge. A cycle model, advanced on the same rising edges as the design, gives the expected values. The directed tests count edges one at a time so that each check lands exactly on the cycle where its result is due.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int EDGE_LSB = 3;
  localparam int EDGE_W   = 2;
  localparam int SYNC_BIT = 6;
  localparam int POS_LSB  = 8;
  localparam int NEG_LSB  = 11;
  localparam int SEL_W    = 3;
  localparam int CLR_BIT  = 20;
  localparam int STAT_BIT = 21;
  localparam int FLAG_BIT = 23;
  localparam int HYS_LSB  = 25;
  localparam int HYS_W    = 2;
  localparam int WORD_W   = 32;

  typedef enum logic [EDGE_W-1:0] {
    EDGE_FALL     = 2'd0,
    EDGE_RISE     = 2'd1,
    EDGE_BOTH     = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edge_mode_e;

  // Writable bits of the control word
  function automatic logic [WORD_W-1:0] cfg_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[EDGE_LSB +: EDGE_W] = '1;
    m[SYNC_BIT]           = 1'b1;
    m[POS_LSB +: SEL_W]   = '1;
    m[NEG_LSB +: SEL_W]   = '1;
    m[CLR_BIT]            = 1'b1;
    m[HYS_LSB +: HYS_W]   = '1;
    return m;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o,
  output logic prev_o
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      stg_q  <= {stg_q[STAGES-2:0], raw_i};
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag
  import cmp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EDGE_W-1:0] mode_i,
  input  logic              sync_i,
  input  logic              prev_i,
  input  logic              hold_i,
  output logic              flag_o
);
  logic rise, fall, hit, flag_q;

  always_comb begin
    rise = sync_i & ~prev_i;
    fall = ~sync_i & prev_i;
    case (edge_mode_e'(mode_i))
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hold_i) flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_cfg_regs.sv
module cmp_cfg_regs
  import cmp_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              clr_next_o
);
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(cfg_mask());

  logic [DATA_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) cfg_d = wdata_i & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o      = cfg_q;
  // Clear level for the coming cycle; a write of 0 releases the hold on its own edge
  assign clr_next_o = cfg_d[CLR_BIT];
endmodule

// File: rtl/cmp_edge_ctrl.sv
module cmp_edge_ctrl
  import cmp_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_raw_i,
  output logic [SEL_W-1:0]  pos_sel_o,
  output logic [SEL_W-1:0]  neg_sel_o,
  output logic [HYS_W-1:0]  hys_sel_o,
  output logic              cmp_out_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cfg;
  logic              clr_next, sync_lvl, prev_lvl, flag;
  logic [DATA_W-1:0] status;

  cmp_cfg_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_en), .wdata_i(bus_wdata),
    .cfg_o(cfg), .clr_next_o(clr_next)
  );

  cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(cmp_raw_i),
    .sync_o(sync_lvl), .prev_o(prev_lvl)
  );

  cmp_edge_flag flag_i (
    .clk(clk), .rst_n(rst_n), .mode_i(cfg[EDGE_LSB +: EDGE_W]),
    .sync_i(sync_lvl), .prev_i(prev_lvl), .hold_i(clr_next), .flag_o(flag)
  );

  always_comb begin
    status           = '0;
    status[STAT_BIT] = sync_lvl;
    status[FLAG_BIT] = flag;
  end

  assign bus_rdata = cfg | status;
  assign pos_sel_o = cfg[POS_LSB +: SEL_W];
  assign neg_sel_o = cfg[NEG_LSB +: SEL_W];
  assign hys_sel_o = cfg[HYS_LSB +: HYS_W];
  assign cmp_out_o = cfg[SYNC_BIT] ? sync_lvl : cmp_raw_i;
  assign irq_o     = flag;
endmodule

// File: rtl/cmp_edge_ctrl_chk.sv
module cmp_edge_ctrl_chk
  import cmp_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cmp_raw_i,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] LIVE = DATA_W'(cfg_mask()) |
                                       (DATA_W'(1) << STAT_BIT) | (DATA_W'(1) << FLAG_BIT);

  // R6
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[CLR_BIT] |-> !irq_o);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(bus_wr_en && bus_wdata[CLR_BIT])) |=> irq_o);

  // R3
  stat_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[STAT_BIT]) |-> $past(cmp_raw_i, 2));

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(bus_rdata[STAT_BIT]) != $past(bus_rdata[STAT_BIT], 2)));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE) == '0);
endmodule

bind cmp_edge_ctrl cmp_edge_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cmp_raw_i(cmp_raw_i), .irq_o(irq_o)
);

// File: tb/cmp_edge_ctrl_tb_top.sv
module cmp_edge_ctrl_tb_top;
  localparam logic [31:0] MASK = 32'h0610_3F58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_raw_i = 1'b0;
  logic [2:0]  pos_sel_o, neg_sel_o;
  logic [1:0]  hys_sel_o;
  logic        cmp_out_o, irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cmp_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_raw_i(cmp_raw_i), .pos_sel_o(pos_sel_o),
    .neg_sel_o(neg_sel_o), .hys_sel_o(hys_sel_o), .cmp_out_o(cmp_out_o), .irq_o(irq_o)
  );

  // Reference model built from the requirements
  logic [31:0] m_cfg = '0;
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0, m_flag = 1'b0;

  function automatic bit edge_hit(logic [1:0] mode, logic prv, logic cur);
    bit r = !prv && cur;
    bit f = prv && !cur;
    if (mode == 2'd0) return f;
    if (mode == 2'd1) return r;
    return r || f;
  endfunction

  function automatic logic [31:0] exp_rdata();
    return m_cfg | (32'(m_s2) << 21) | (32'(m_flag) << 23);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= '0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0;
    end else begin
      logic clr_n;
      clr_n = bus_wr_en ? bus_wdata[20] : m_cfg[20];
      if (bus_wr_en) m_cfg <= bus_wdata & MASK;
      m_s1 <= cmp_raw_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (clr_n) m_flag <= 0;
      else if (edge_hit(m_cfg[4:3], m_prev, m_s2)) m_flag <= 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    check({tag, " R2 rdata"}, bus_rdata, exp_rdata());
    check({tag, " R2 pos"}, 32'(pos_sel_o), 32'(m_cfg[10:8]));
    check({tag, " R2 neg"}, 32'(neg_sel_o), 32'(m_cfg[13:11]));
    check({tag, " R2 hys"}, 32'(hys_sel_o), 32'(m_cfg[26:25]));
    check({tag, " R5 irq"}, 32'(irq_o), 32'(m_flag));
    check({tag, " R9 out"}, 32'(cmp_out_o), 32'(m_cfg[6] ? m_s2 : cmp_raw_i));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [31:0] v);
    bus_wr_en = 1'b1; bus_wdata = v;
    tick();
    bus_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(int edge_m, int snc, int pos, int neg, int hys, int clr);
    return (32'(edge_m) << 3) | (32'(snc) << 6) | (32'(pos) << 8) | (32'(neg) << 11) |
           (32'(clr) << 20) | (32'(hys) << 25);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 outs", {24'h0, pos_sel_o, neg_sel_o, hys_sel_o}, 32'h0);
    check("R1 irq", {30'h0, cmp_out_o, irq_o}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2: field storage and select outputs
    wr(cfgw(1, 0, 5, 6, 3, 0));
    check("R2 pos", 32'(pos_sel_o), 32'd5);
    check("R2 neg", 32'(neg_sel_o), 32'd6);
    check("R2 hys", 32'(hys_sel_o), 32'd3);
    check("R2 rdata", bus_rdata, cfgw(1, 0, 5, 6, 3, 0));

    // R8: write all ones; status bits and unused bits are unaffected
    wr(32'hFFFF_FFFF);
    check("R8 rdata", bus_rdata, MASK);
    wr(cfgw(1, 0, 0, 0, 0, 0));

    // R9 raw path, R3 latency, R4 rising detect
    cmp_raw_i = 1'b1;
    #1 check("R9 raw out", 32'(cmp_out_o), 32'd1);
    tick(); check("R3 stat@1", 32'(bus_rdata[21]), 32'd0);
    tick(); check("R3 stat@2", 32'(bus_rdata[21]), 32'd1);
    check("R4 irq not yet", 32'(irq_o), 32'd0);
    tick(); check("R4 rise sets", 32'(irq_o), 32'd1);

    // R5: sticky through a falling edge not selected
    cmp_raw_i = 1'b0;
    tick(4); check("R5 sticky", {bus_rdata[23], irq_o}, 32'd3);

    // R6: clear and hold against new edges
    wr(cfgw(2, 0, 0, 0, 0, 1));
    check("R6 clear", 32'(irq_o), 32'd0);
    cmp_raw_i = 1'b1; tick(4);
    cmp_raw_i = 1'b0; tick(4);
    check("R6 held", {bus_rdata[23], irq_o}, 32'd0);

    // R7: release coincides with a detected edge
    cmp_raw_i = 1'b1;
    tick(2);
    wr(cfgw(2, 0, 0, 0, 0, 0));
    check("R7 edge wins", 32'(irq_o), 32'd1);

    // R4: falling-only mode ignores a rise
    wr(cfgw(0, 0, 0, 0, 0, 1));
    wr(cfgw(0, 0, 0, 0, 0, 0));
    cmp_raw_i = 1'b0; tick(4);
    check("R4 fall sets", 32'(irq_o), 32'd1);
    wr(cfgw(0, 0, 0, 0, 0, 1));
    wr(cfgw(0, 0, 0, 0, 0, 0));
    cmp_raw_i = 1'b1; tick(4);
    check("R4 rise ignored", 32'(irq_o), 32'd0);

    // R9: synchronized path lags two edges
    wr(cfgw(3, 1, 0, 0, 0, 0));
    cmp_raw_i = 1'b0;
    #1 check("R9 sync hold", 32'(cmp_out_o), 32'd1);
    tick(2); check("R9 sync new", 32'(cmp_out_o), 32'd0);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      bus_wr_en = ($urandom % 4) == 0;
      bus_wdata = $urandom;
      if (($urandom % 3) == 0) bus_wdata[20] = 1'b0;
      if (($urandom % 6) == 0) cmp_raw_i = ~cmp_raw_i;
      #1 check_model("rand");
      tick();
      check_model("rand");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule